// File: doc/BRIEF.md
# Wall-Following Maze Robot Controller

This block is the decision core of a small maze-crawling robot. The robot has two contact feelers, one on each side, each reading 1 while it presses against something. The controller is a four-state Moore machine that keeps the right feeler brushing along a wall. On every clock it issues some mix of three motion commands: a forward step, a small left turn and a small right turn. A motor stage downstream consumes these commands one cycle at a time.

After reset the robot is searching. It walks straight ahead until either feeler makes contact. It then spins counter-clockwise until both feelers are free. From there it alternates between two gaits. In the seek gait it steps forward while veering right, so that it finds the wall again. In the leave gait it steps forward while veering left, so that it pulls off the wall. An outside corner needs the same step-and-veer-right action as seeking the wall, so it is handled by the seek gait and needs no state of its own. A left-feeler hit in either gait sends the robot back to spinning.

The feeler inputs must already be synchronous to the clock. Reset is synchronous and active high.

Top module: `wall_follow_ctrl`

## Requirements
- R1: While reset is high at a clock edge, the machine enters the search state (state code 00). In the cycle after that edge the outputs read step_fwd=1, turn_left=0, turn_right=0.
- R2: In the search state the only command is a forward step. The machine stays in search while both feelers read 0.
- R3: In the search state, contact on either feeler moves the machine to the spin state at the next edge.
- R4: In the spin state the only command is turn_left. The machine stays in spin while at least one feeler reads 1.
- R5: In the spin state, with both feelers at 0, the machine moves to the seek gait at the next edge.
- R6: The seek gait drives step_fwd and turn_right together, with turn_left at 0. A left-feeler contact in seek moves the machine to spin, and this takes priority over the right feeler.
- R7: In the seek gait, right-feeler contact alone moves the machine to the leave gait. With no contact at all it stays in seek.
- R8: The leave gait drives step_fwd and turn_left together, with turn_right at 0. A left-feeler contact in leave moves the machine to spin, regardless of the right feeler.
- R9: In the leave gait it stays in leave while only the right feeler touches. With no contact at all it returns to seek.
- R10: turn_left and turn_right are never 1 in the same cycle, and at least one of the three commands is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ant_l | input | 1 | Left feeler, 1 while touching |
| ant_r | input | 1 | Right feeler, 1 while touching |
| step_fwd | output | 1 | Forward step command |
| turn_left | output | 1 | Small left turn command |
| turn_right | output | 1 | Small right turn command |

## Verification
Some transitions only happen deep in a sequence, which makes them the hardest to reach from the ports. The leave gait's left-feeler exit and the case where both feelers touch in the seek gait are examples. To reach the leave gait, the stimulus must first touch a feeler, then free both feelers, and only then press the right feeler. The directed part of the bench walks these exact sequences, including both feelers at once in each gait. A long pseudo-random feeler stream then follows, and a behavioural model predicts the command pattern on every clock.

// File: rtl/wf_pkg.sv
package wf_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        WF_SEARCH = 2'b00,
        WF_SPIN   = 2'b01,
        WF_SEEK   = 2'b10,
        WF_LEAVE  = 2'b11
    } wf_state_e;

    typedef struct packed {
        logic fwd;
        logic left;
        logic right;
    } wf_cmd_t;

    typedef struct packed {
        wf_state_e state;
    } wf_regs_t;

endpackage

// File: rtl/wf_step_logic.sv
module wf_step_logic
    import wf_pkg::*;
(
    input  wf_state_e cur,
    input  logic      feel_l,
    input  logic      feel_r,
    output wf_state_e nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            WF_SEARCH: if (feel_l || feel_r) nxt = WF_SPIN;
            WF_SPIN:   if (!feel_l && !feel_r) nxt = WF_SEEK;
            WF_SEEK: begin
                if (feel_l)      nxt = WF_SPIN;
                else if (feel_r) nxt = WF_LEAVE;
            end
            WF_LEAVE: begin
                if (feel_l)       nxt = WF_SPIN;
                else if (!feel_r) nxt = WF_SEEK;
            end
            default: nxt = WF_SEARCH;
        endcase
    end
endmodule

// File: rtl/wf_act_decode.sv
module wf_act_decode
    import wf_pkg::*;
(
    input  wf_state_e cur,
    output wf_cmd_t   cmd
);
    always_comb begin
        cmd = '0;
        unique case (cur)
            WF_SEARCH: cmd.fwd = 1'b1;
            WF_SPIN:   cmd.left = 1'b1;
            WF_SEEK: begin
                cmd.fwd   = 1'b1;
                cmd.right = 1'b1;
            end
            WF_LEAVE: begin
                cmd.fwd  = 1'b1;
                cmd.left = 1'b1;
            end
            default: cmd.fwd = 1'b1;
        endcase
    end
endmodule

// File: rtl/wall_follow_ctrl.sv
module wall_follow_ctrl
    import wf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ant_l,
    input  logic ant_r,
    output logic step_fwd,
    output logic turn_left,
    output logic turn_right
);
    wf_regs_t  regs_d;
    wf_regs_t  regs_q;
    wf_state_e step_nxt;
    wf_cmd_t   cmd;

    wf_step_logic u_step (
        .cur    (regs_q.state),
        .feel_l (ant_l),
        .feel_r (ant_r),
        .nxt    (step_nxt)
    );

    wf_act_decode u_act (
        .cur (regs_q.state),
        .cmd (cmd)
    );

    always_comb begin
        regs_d = regs_q;
        regs_d.state = step_nxt;
        if (rst) regs_d.state = WF_SEARCH;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign step_fwd   = cmd.fwd;
    assign turn_left  = cmd.left;
    assign turn_right = cmd.right;
endmodule

// File: rtl/wf_chk.sv
module wf_chk (
    input logic clk,
    input logic rst,
    input logic ant_l,
    input logic ant_r,
    input logic step_fwd,
    input logic turn_left,
    input logic turn_right
);
    logic in_search, in_spin, in_seek, in_leave;
    assign in_search = step_fwd && !turn_left && !turn_right;
    assign in_spin   = !step_fwd && turn_left && !turn_right;
    assign in_seek   = step_fwd && !turn_left && turn_right;
    assign in_leave  = step_fwd && turn_left && !turn_right;

    // R10
    turn_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(turn_left && turn_right) && (step_fwd || turn_left));

    // R3
    search_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_search && (ant_l || ant_r)) |=> in_spin);

    // R2
    search_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_search && !ant_l && !ant_r) |=> in_search);

    // R5
    spin_free_chk: assert property (@(posedge clk) disable iff (rst)
        (in_spin && !ant_l && !ant_r) |=> in_seek);

    // R6
    seek_left_chk: assert property (@(posedge clk) disable iff (rst)
        (in_seek && ant_l) |=> in_spin);

    // R7
    seek_right_chk: assert property (@(posedge clk) disable iff (rst)
        (in_seek && !ant_l && ant_r) |=> in_leave);

    // R8
    leave_left_chk: assert property (@(posedge clk) disable iff (rst)
        (in_leave && ant_l) |=> in_spin);

    // R9
    leave_free_chk: assert property (@(posedge clk) disable iff (rst)
        (in_leave && !ant_l && !ant_r) |=> in_seek);
endmodule

bind wall_follow_ctrl wf_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ant_l      (ant_l),
    .ant_r      (ant_r),
    .step_fwd   (step_fwd),
    .turn_left  (turn_left),
    .turn_right (turn_right)
);

// File: tb/sim_wall_follow_ctrl.sv
`timescale 1ns/1ps
module sim_wall_follow_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ant_l = 1'b0;
    logic ant_r = 1'b0;
    logic step_fwd, turn_left, turn_right;

    int checks = 0;
    int errors = 0;
    int model = 0; // 0 search, 1 spin, 2 seek, 3 leave
    string tag = "R1";
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    wall_follow_ctrl u0 (
        .clk(clk), .rst(rst), .ant_l(ant_l), .ant_r(ant_r),
        .step_fwd(step_fwd), .turn_left(turn_left), .turn_right(turn_right)
    );

    function automatic logic [2:0] expect_cmd(int s);
        case (s)
            0: return 3'b100;
            1: return 3'b010;
            2: return 3'b101;
            default: return 3'b110;
        endcase
    endfunction

    task automatic check_out(string req);
        logic [2:0] got;
        logic [2:0] exp;
        got = {step_fwd, turn_left, turn_right};
        exp = expect_cmd(model);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: cmd(fwd,left,right)=%b expected %b", req, got, exp);
        end
        if (turn_left && turn_right) begin
            errors++;
            $display("FAIL R10: both turns high, got %b expected not 011", got);
        end
    endtask

    // Advance the model one edge; tag names the rule applied.
    task automatic model_step(logic l, logic r);
        case (model)
            0: begin
                if (l || r) begin model = 1; tag = "R3"; end
                else tag = "R2";
            end
            1: begin
                if (!l && !r) begin model = 2; tag = "R5"; end
                else tag = "R4";
            end
            2: begin
                if (l) begin model = 1; tag = "R6"; end
                else if (r) begin model = 3; tag = "R7"; end
                else tag = "R7";
            end
            default: begin
                if (l) begin model = 1; tag = "R8"; end
                else if (!r) begin model = 2; tag = "R9"; end
                else tag = "R9";
            end
        endcase
    endtask

    task automatic step(logic l, logic r);
        ant_l = l;
        ant_r = r;
        @(posedge clk);
        model_step(l, r);
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ant_l = 1'b1;
        ant_r = 1'b1;
        @(posedge clk);
        @(posedge clk);
        model = 0;
        @(negedge clk);
        rst = 1'b0;
        ant_l = 1'b0;
        ant_r = 1'b0;
        check_out("R1");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R2: search holds
        step(0, 0); step(0, 0);
        // R3: right contact starts spin; R4 spin holds on contact
        step(0, 1); step(1, 0); step(1, 1); step(0, 1);
        // R5: free -> seek; R7 hold seek
        step(0, 0); step(0, 0);
        // R6: both in seek -> spin (left wins)
        step(1, 1);
        step(0, 0);
        // R7: right only -> leave; R9 hold on right
        step(0, 1); step(0, 1);
        // R9: free -> seek
        step(0, 0);
        step(0, 1);
        // R8: left with right in leave -> spin
        step(1, 1);
        step(0, 0); step(0, 1);
        // R8: left only in leave
        step(1, 0);
        step(0, 0);
        // R6: left only in seek
        step(1, 0);
        // R3: left contact from search after mid-run reset (R1)
        do_reset();
        step(1, 0);
        step(0, 0);
        // Pseudo-random stream
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] & lfsr[3], lfsr[1] | lfsr[5]);
            if (i == 300) do_reset();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule